// File: doc/BRIEF.md
# Two-tier interrupt prioritizer with vector address generation

This block collects peripheral interrupt requests and chooses one to present to a processor core. Each request line has its own enable input. A source is pending only while both its request and its enable are high. Every source has a fixed interrupt level (1 to 7) and a fixed slot within that level. The pending source with the highest level wins. When two pending sources share a level, the higher slot wins.

The block reports the winner's level and its 8-bit vector number. It also reports the 32-bit handler-table address. This address is formed from the 1 MB-aligned table base plus four times the vector number. A take flag compares the winning level with the mask level supplied by the core. A next-PC indicator marks every interrupt that is taken, because interrupts always resume at the next instruction.

Two level-6 slots can be retargeted through 8-bit select inputs. Each select names the vector of a source that is promoted into that slot. The winner is captured into registers and held until the core acknowledges it.

The controller has two states:
- ST_IDLE: nothing is presented. If any source is pending at a clock edge, the block captures the winner and moves to ST_HOLD.
- ST_HOLD: the captured winner is held. When ack is high at a clock edge, the block returns to ST_IDLE, and the next arbitration happens one edge later.

Top module: `intc_vector_top`

## Requirements
- R1: After reset, irq_valid, irq_take and irq_next_pc are low, and nothing is presented until a source becomes pending.
- R2: A source is pending only when its request and its enable are both high. A request whose enable is low never produces a presentation.
- R3: The low-voltage source (index 1) is pending when its detect pair (src_req[1] with src_en[1]) is active, and also when its warning pair (lvw_req with lvw_en) is active.
- R4: A pending source at a higher level always wins over any source at a lower level, whatever their slots.
- R5: Slots inside a level use a 4-bit code: numbered slot p is coded 2p, and the pin's mid slot is coded 7. So the pin (index 0, level 7) beats low-voltage (index 1, level 7, slot 3) and clock-lock loss (index 2, level 7, slot 2). The timer (index 3) sits at level 6, slot 5.
- R6: The vector of source index i is 64 + i: 64 for the pin, 65 for low-voltage, 66 for lock loss and 67 for the timer.
- R7: irq_addr equals vbr with bits 19:0 cleared, plus 4 × irq_vector. The low 20 bits of vbr have no effect.
- R8: While irq_valid is high and ack is low, irq_level, irq_vector and irq_addr stay unchanged, even if a higher source becomes pending.
- R9: When ack is high at an edge in ST_HOLD, irq_valid is low after that edge. The next winner, if any, is presented after the following edge.
- R10: irq_take is high when irq_valid is high and irq_level is 7, or when irq_level is strictly greater than mask_lvl. Otherwise irq_take is low.
- R11: irq_next_pc is high exactly when irq_take is high.
- R12: If remap_a equals a source's vector, that source competes at level 6 with slot code 14 (slot 7). Otherwise, if remap_b equals the vector, the source competes at level 6 with slot code 12 (slot 6). A select value that names no source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Request lines, index 0 pin, 1 low-voltage detect, 2 lock loss, 3 timer |
| src_en | input | N_SRC | Enable for each request line |
| lvw_req | input | 1 | Low-voltage warning request |
| lvw_en | input | 1 | Low-voltage warning enable |
| remap_a | input | 8 | Vector promoted into level 6, slot 7 |
| remap_b | input | 8 | Vector promoted into level 6, slot 6 |
| vbr | input | 32 | Vector table base; only bits 31:20 are used |
| mask_lvl | input | 3 | Current mask level from the core |
| ack | input | 1 | Core accepts the presented interrupt |
| irq_valid | output | 1 | A winner is presented (ST_HOLD) |
| irq_level | output | 3 | Effective level of the presented source |
| irq_vector | output | 8 | Vector number of the presented source |
| irq_addr | output | 32 | Handler-table entry address |
| irq_take | output | 1 | Presented level passes the mask |
| irq_next_pc | output | 1 | The taken interrupt stacks the next-instruction address |

## Verification
The checker module tests these behaviours on every cycle:
- The presented values stay stable while ack is low.
- irq_valid drops after an acknowledge.
- No presentation appears when no source is pending.
- irq_take obeys the mask rule.
- The vector stays in range and the address agrees with the vector.

Only the bench's directed scenarios can show which source wins. These scenarios cover level ordering, the mid slot, the OR of the two low-voltage pairs, and the effect of the remap selects. They also check the exact base-address arithmetic.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } intc_state_e;

    // Default level of each source index.
    function automatic logic [2:0] dflt_level(input int idx);
        case (idx)
            0, 1, 2: return 3'd7;
            3:       return 3'd6;
            default: return 3'd5;
        endcase
    endfunction

    // In-level slot code: numbered slot p -> 2p, pin mid slot -> 7.
    function automatic logic [3:0] dflt_slot(input int idx);
        case (idx)
            0:       return 4'd7;
            1:       return 4'd6;
            2:       return 4'd4;
            3:       return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/intc_src_key.sv
module intc_src_key #(
    parameter int N_SRC     = 4,
    parameter int LVL_W     = 3,
    parameter int SLOT_W    = 4,
    parameter int VEC_W     = 8,
    parameter int VEC_BASE  = 64,
    parameter int LVD_IDX   = 1,
    parameter int REMAP_LVL = 6,
    parameter int REMAP_A_SLOT = 14,
    parameter int REMAP_B_SLOT = 12,
    localparam int KEY_W    = LVL_W + SLOT_W
) (
    input  logic [N_SRC-1:0]            src_req,
    input  logic [N_SRC-1:0]            src_en,
    input  logic                        lvw_req,
    input  logic                        lvw_en,
    input  logic [VEC_W-1:0]            remap_a,
    input  logic [VEC_W-1:0]            remap_b,
    output logic [N_SRC-1:0]            pend,
    output logic [N_SRC-1:0][KEY_W-1:0] key
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(VEC_BASE + g);
        localparam logic [KEY_W-1:0] DFLT_KEY =
            {LVL_W'(intc_pkg::dflt_level(g)), SLOT_W'(intc_pkg::dflt_slot(g))};

        if (g == LVD_IDX) begin : g_dual
            assign pend[g] = (src_req[g] & src_en[g]) | (lvw_req & lvw_en);
        end else begin : g_single
            assign pend[g] = src_req[g] & src_en[g];
        end

        always_comb begin
            if (remap_a == MY_VEC)
                key[g] = {LVL_W'(REMAP_LVL), SLOT_W'(REMAP_A_SLOT)};
            else if (remap_b == MY_VEC)
                key[g] = {LVL_W'(REMAP_LVL), SLOT_W'(REMAP_B_SLOT)};
            else
                key[g] = DFLT_KEY;
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N_SRC = 4,
    parameter int KEY_W = 7,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]            pend,
    input  logic [N_SRC-1:0][KEY_W-1:0] key,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx,
    output logic [KEY_W-1:0]            win_key
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_key   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (!win_valid || key[i] > win_key)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_key   = key[i];
            end
        end
    end
endmodule

// File: rtl/intc_vector_top.sv
module intc_vector_top #(
    parameter int N_SRC    = 4,
    parameter int LVL_W    = 3,
    parameter int SLOT_W   = 4,
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int ALIGN    = 20,
    parameter int VEC_BASE = 64,
    parameter int LVD_IDX  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic [N_SRC-1:0]  src_en,
    input  logic              lvw_req,
    input  logic              lvw_en,
    input  logic [VEC_W-1:0]  remap_a,
    input  logic [VEC_W-1:0]  remap_b,
    input  logic [ADDR_W-1:0] vbr,
    input  logic [LVL_W-1:0]  mask_lvl,
    input  logic              ack,
    output logic              irq_valid,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [ADDR_W-1:0] irq_addr,
    output logic              irq_take,
    output logic              irq_next_pc
);
    import intc_pkg::*;

    localparam int KEY_W = LVL_W + SLOT_W;
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [LVL_W-1:0] NMI_LVL = '1;

    logic [N_SRC-1:0]            pend;
    logic [N_SRC-1:0][KEY_W-1:0] key;
    logic                        win_valid;
    logic [IDX_W-1:0]            win_idx;
    logic [KEY_W-1:0]            win_key;
    logic [VEC_W-1:0]            win_vec;
    logic [ADDR_W-1:0]           win_addr;
    logic                        vbr_unused_lo;

    intc_state_e state, state_nxt;
    logic [LVL_W-1:0]  lvl_q;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] addr_q;

    intc_src_key #(
        .N_SRC(N_SRC), .LVL_W(LVL_W), .SLOT_W(SLOT_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .LVD_IDX(LVD_IDX)
    ) u_key (
        .src_req(src_req), .src_en(src_en),
        .lvw_req(lvw_req), .lvw_en(lvw_en),
        .remap_a(remap_a), .remap_b(remap_b),
        .pend(pend), .key(key)
    );

    intc_arbiter #(.N_SRC(N_SRC), .KEY_W(KEY_W)) u_arb (
        .pend(pend), .key(key),
        .win_valid(win_valid), .win_idx(win_idx), .win_key(win_key)
    );

    assign vbr_unused_lo = ^vbr[ALIGN-1:0];
    assign win_vec  = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    assign win_addr = {vbr[ADDR_W-1:ALIGN], {ALIGN{1'b0}}}
                    + {{(ADDR_W-VEC_W-2){1'b0}}, win_vec, 2'b00};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (win_valid) state_nxt = ST_HOLD;
            ST_HOLD: if (ack)       state_nxt = ST_IDLE;
        endcase
    end

    // Capture of the winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            vec_q  <= '0;
            addr_q <= '0;
        end else if (state == ST_IDLE && win_valid) begin
            lvl_q  <= win_key[KEY_W-1 -: LVL_W];
            vec_q  <= win_vec;
            addr_q <= win_addr;
        end
    end

    // Outputs
    always_comb begin
        irq_valid   = (state == ST_HOLD);
        irq_level   = lvl_q;
        irq_vector  = vec_q;
        irq_addr    = addr_q;
        irq_take    = irq_valid && ((lvl_q == NMI_LVL) || (lvl_q > mask_lvl));
        irq_next_pc = irq_take;
    end
endmodule

// File: rtl/intc_vector_chk.sv
module intc_vector_chk #(
    parameter int N_SRC    = 4,
    parameter int VEC_BASE = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req,
    input logic [N_SRC-1:0] src_en,
    input logic             lvw_req,
    input logic             lvw_en,
    input logic [2:0]       mask_lvl,
    input logic             ack,
    input logic             irq_valid,
    input logic [2:0]       irq_level,
    input logic [7:0]       irq_vector,
    input logic [31:0]      irq_addr,
    input logic             irq_take
);
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !ack) |=> (irq_valid && $stable(irq_vector)
                                 && $stable(irq_level) && $stable(irq_addr)));

    a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && ack) |=> !irq_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid && ((src_req & src_en) == '0) && !(lvw_req && lvw_en)) |=> !irq_valid);

    a_r10_take_rule: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_valid && (irq_level == 3'd7 || irq_level > mask_lvl)));

    a_r10_take_due: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_level == 3'd7) |-> irq_take);

    a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector >= 8'(VEC_BASE) && irq_vector < 8'(VEC_BASE + N_SRC)));

    a_r7_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_addr[9:2] == irq_vector && irq_addr[1:0] == 2'b00
                       && irq_addr[19:10] == 10'd0));
endmodule

bind intc_vector_top intc_vector_chk #(.N_SRC(N_SRC), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .lvw_req(lvw_req), .lvw_en(lvw_en), .mask_lvl(mask_lvl), .ack(ack),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector),
    .irq_addr(irq_addr), .irq_take(irq_take)
);

// File: tb/intc_vector_top_test.sv
`timescale 1ns/1ps
module intc_vector_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_req = '0, src_en = '0;
    logic        lvw_req = 1'b0, lvw_en = 1'b0;
    logic [7:0]  remap_a = 8'd0, remap_b = 8'd0;
    logic [31:0] vbr = 32'h0080_0000;
    logic [2:0]  mask_lvl = 3'd0;
    logic        ack = 1'b0;
    logic        irq_valid, irq_take, irq_next_pc;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;
    logic [31:0] irq_addr;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    intc_vector_top uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .lvw_req(lvw_req), .lvw_en(lvw_en), .remap_a(remap_a), .remap_b(remap_b),
        .vbr(vbr), .mask_lvl(mask_lvl), .ack(ack),
        .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector),
        .irq_addr(irq_addr), .irq_take(irq_take), .irq_next_pc(irq_next_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, then sample just after the next rising edge.
    task automatic drive(input logic [3:0] rq, input logic [3:0] en);
        @(negedge clk);
        src_req = rq;
        src_en  = en;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_win(input string tag, input logic [7:0] vec, input logic [2:0] lvl);
        chk({tag, " valid"}, 32'(irq_valid), 32'd1);
        chk({tag, " vector"}, 32'(irq_vector), 32'(vec));
        chk({tag, " level"}, 32'(irq_level), 32'(lvl));
    endtask

    // Acknowledge, clear every request, and return to idle.
    task automatic release_all();
        @(negedge clk);
        ack = 1'b1;
        src_req = '0; src_en = '0; lvw_req = 1'b0; lvw_en = 1'b0;
        @(posedge clk);
        #1;
        ack = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", 32'(irq_valid), 32'd0);
        chk("R1 take after reset", 32'(irq_take), 32'd0);
        chk("R1 next_pc after reset", 32'(irq_next_pc), 32'd0);
    endtask

    task automatic t_enable_gate();
        drive(4'b1000, 4'b0000);
        chk("R2 disabled request ignored", 32'(irq_valid), 32'd0);
        drive(4'b0000, 4'b1000);
        chk("R2 enable without request", 32'(irq_valid), 32'd0);
        drive(4'b1000, 4'b1000);
        expect_win("R2 timer enabled", 8'd67, 3'd6);
        release_all();
    endtask

    task automatic t_lvd_or();
        @(negedge clk);
        lvw_req = 1'b1; lvw_en = 1'b0;
        drive(4'b0000, 4'b0000);
        chk("R3 warning disabled", 32'(irq_valid), 32'd0);
        @(negedge clk);
        lvw_en = 1'b1;
        drive(4'b0000, 4'b0000);
        expect_win("R3 warning pair", 8'd65, 3'd7);
        release_all();
        drive(4'b0010, 4'b0010);
        expect_win("R3 detect pair", 8'd65, 3'd7);
        release_all();
    endtask

    task automatic t_ordering();
        drive(4'b1100, 4'b1100);
        expect_win("R4 level 7 beats level 6", 8'd66, 3'd7);
        release_all();
        drive(4'b0111, 4'b0111);
        expect_win("R5 mid slot beats slot 3 and 2", 8'd64, 3'd7);
        release_all();
        drive(4'b0110, 4'b0110);
        expect_win("R5 slot 3 beats slot 2", 8'd65, 3'd7);
        release_all();
        drive(4'b0001, 4'b0001);
        expect_win("R6 pin vector", 8'd64, 3'd7);
        release_all();
    endtask

    task automatic t_address();
        @(negedge clk);
        vbr = 32'h0080_0000;
        drive(4'b0001, 4'b0001);
        chk("R7 pin address", irq_addr, 32'h0080_0100);
        release_all();
        @(negedge clk);
        vbr = 32'h123F_FFFF;
        drive(4'b1000, 4'b1000);
        chk("R7 low base bits ignored", irq_addr, 32'h1230_010C);
        release_all();
        @(negedge clk);
        vbr = 32'h0080_0000;
    endtask

    task automatic t_hold_and_rearb();
        drive(4'b0100, 4'b0100);
        expect_win("R8 lock captured", 8'd66, 3'd7);
        drive(4'b0101, 4'b0101);
        @(posedge clk);
        #1;
        expect_win("R8 held despite pin", 8'd66, 3'd7);
        chk("R8 address held", irq_addr, 32'h0080_0108);
        // Acknowledge while pin and timer stay pending.
        @(negedge clk);
        ack = 1'b1;
        src_req = 4'b1001; src_en = 4'b1001;
        @(posedge clk);
        #1;
        chk("R9 valid low after ack", 32'(irq_valid), 32'd0);
        ack = 1'b0;
        @(posedge clk);
        #1;
        expect_win("R9 re-arbitrated pin", 8'd64, 3'd7);
        release_all();
    endtask

    task automatic t_mask();
        drive(4'b1000, 4'b1000);
        @(negedge clk); mask_lvl = 3'd5; #1;
        chk("R10 level 6 over mask 5", 32'(irq_take), 32'd1);
        chk("R11 next_pc with take", 32'(irq_next_pc), 32'd1);
        @(negedge clk); mask_lvl = 3'd6; #1;
        chk("R10 level 6 at mask 6 blocked", 32'(irq_take), 32'd0);
        chk("R11 next_pc without take", 32'(irq_next_pc), 32'd0);
        release_all();
        @(negedge clk); mask_lvl = 3'd7;
        drive(4'b0001, 4'b0001);
        chk("R10 level 7 ignores mask", 32'(irq_take), 32'd1);
        release_all();
        @(negedge clk); mask_lvl = 3'd0;
    endtask

    task automatic t_remap();
        @(negedge clk); remap_a = 8'd66;
        drive(4'b1100, 4'b1100);
        expect_win("R12 lock promoted to level 6 slot 7", 8'd66, 3'd6);
        release_all();
        drive(4'b1101, 4'b1101);
        expect_win("R12 level 7 pin still wins", 8'd64, 3'd7);
        release_all();
        @(negedge clk); remap_a = 8'd65; remap_b = 8'd67;
        drive(4'b1010, 4'b1010);
        expect_win("R12 slot A beats slot B", 8'd65, 3'd6);
        release_all();
        @(negedge clk); remap_a = 8'd67; remap_b = 8'd67;
        drive(4'b1000, 4'b1000);
        expect_win("R12 A wins same select", 8'd67, 3'd6);
        release_all();
        @(negedge clk); remap_a = 8'd200; remap_b = 8'd0;
        drive(4'b0110, 4'b0110);
        expect_win("R12 unused select no effect", 8'd65, 3'd7);
        release_all();
        @(negedge clk); remap_a = 8'd0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 idle after release of reset", 32'(irq_valid), 32'd0);
        t_enable_gate();
        t_lvd_or();
        t_ordering();
        t_address();
        t_hold_and_rearb();
        t_mask();
        t_remap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule